// File: doc/BRIEF.md
# Fine Phase-Step Sequencer

This block drives the dynamic fine phase-shift port of an on-chip clock synthesizer. The port moves the synthesizer's oscillator output by one fine step of 1/STEPS of the oscillator period each time it is asked. Every request is a single step-enable pulse that carries an increment or decrement select, and the port answers each step with a done pulse some cycles later. User logic presents a signed target position in fine steps. The sequencer tracks the present position as an index that wraps modulo one full oscillator period. It chooses the direction that reaches the target in fewer steps and issues single steps, one at a time, until the index equals the target.

The block runs on the phase-shift port clock. A target may be issued at any time, including while steps are in flight. The newest target replaces the old one, and the step in progress finishes before the new target governs direction. A target equal to the present index costs no steps, so the shift can be set once and left static, or moved at run time as often as needed.

Top module: `ps_fine_ctrl`

## Requirements
- R1: After reset the present index `cur_phase` is 0, `ps_en` is low and `ready` is high.
- R2: A cycle with `req_valid` high latches `req_phase` as the target. A negative value -k (1 <= k <= STEPS-1) names index STEPS-k. Values from 0 to STEPS-1 name themselves.
- R3: At most one step is outstanding. No `ps_en` pulse is issued between a pulse and the `ps_done` that answers it.
- R4: `ps_en` is high for exactly one clock per step.
- R5: A `ps_done` accepted for a step moves `cur_phase` by one, up when `ps_incdec` was 1 and down when it was 0. Up from STEPS-1 gives 0, and down from 0 gives STEPS-1.
- R6: Each step goes in the direction with the shorter wrapped distance to the target. When both distances are equal, the step is an increment (`ps_incdec` = 1).
- R7: Starting at rest, a move to a new target takes exactly min(d, STEPS-d) steps, where d = (target - start) mod STEPS.
- R8: A target latched while a step is outstanding takes effect once that step completes. The index then settles on the newest target.
- R9: `ready` is high, and `busy` low, exactly when no step is outstanding and the index equals the target. A request for the present index issues no step, and `ready` stays high.
- R10: A `ps_done` that arrives while no step is outstanding is ignored, and `cur_phase` keeps its value.
- R11: `cur_phase` always lies in 0 to STEPS-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase-shift port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Target strobe, one cycle |
| req_phase | input | PW+1 | Signed target in fine steps, -(STEPS-1) to STEPS-1 |
| ready | output | 1 | At target with no step outstanding |
| busy | output | 1 | Inverse of ready |
| cur_phase | output | PW | Present phase index, 0 to STEPS-1 |
| ps_en | output | 1 | Step-enable pulse to the synthesizer |
| ps_incdec | output | 1 | Step direction, 1 = increment, held during the step |
| ps_done | input | 1 | Step-complete pulse from the synthesizer |

## Verification
The bench aims at wrap-around through both ends of the index range. A design that saturates instead of wrapping would stop at 0 or 55 and never reach targets across the boundary. It drives the exact half-period tie: a design that breaks the tie toward decrement gives the wrong direction on every pulse of that move. It also retargets while a step is outstanding, sends a target equal to the present index, and injects a stray done while idle. A design that loses the newer target, issues a needless pulse, or counts the unsolicited done would end on the wrong index or with the wrong step count. Every pulse's direction is compared with a model of the shorter path, and the responder answers after randomized delays to expose any pulse sent before done.

// File: rtl/ps_fine_pkg.sv
package ps_fine_pkg;

  // Step handshake state: at rest, or waiting for the answer to a pulse.
  typedef enum logic [0:0] {
    PS_IDLE = 1'b0,
    PS_WAIT = 1'b1
  } ps_state_e;

endpackage

// File: rtl/ps_rst_sync.sv
module ps_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/ps_dir_pick.sv
module ps_dir_pick #(
  parameter int STEPS = 56,
  parameter int PW    = $clog2(STEPS)
) (
  input  logic [PW-1:0] cur_i,
  input  logic [PW:0]   tgt_i,
  output logic          at_tgt_o,
  output logic          go_inc_o
);

  localparam logic [PW:0] STEPS_W = (PW+1)'(STEPS);

  logic [PW:0] cur_w;
  logic [PW:0] fwd;
  logic [PW:0] bwd;

  assign cur_w = {1'b0, cur_i};

  always_comb begin
    // forward distance, wrapped into 0..STEPS-1
    if (tgt_i >= cur_w) fwd = tgt_i - cur_w;
    else                fwd = tgt_i + STEPS_W - cur_w;
    bwd      = STEPS_W - fwd;
    at_tgt_o = (fwd == '0);
    go_inc_o = (fwd <= bwd);   // equal distances favour increment
  end

endmodule

// File: rtl/ps_phase_acc.sv
module ps_phase_acc #(
  parameter int STEPS = 56,
  parameter int PW    = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          inc_i,
  output logic [PW-1:0] cur_o
);

  localparam logic [PW-1:0] TOP_IDX = PW'(STEPS - 1);

  logic [PW-1:0] cur_q;
  logic [PW-1:0] cur_d;

  always_comb begin
    cur_d = cur_q;
    if (step_i) begin
      if (inc_i) cur_d = (cur_q == TOP_IDX) ? '0 : cur_q + 1'b1;
      else       cur_d = (cur_q == '0) ? TOP_IDX : cur_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (step_i) cur_q <= cur_d;
  end

  assign cur_o = cur_q;

endmodule

// File: rtl/ps_step_fsm.sv
module ps_step_fsm
  import ps_fine_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic at_tgt_i,
  input  logic go_inc_i,
  input  logic done_i,
  output logic en_o,
  output logic incdec_o,
  output logic accept_o,
  output logic wait_o
);

  ps_state_e state_q, state_d;
  logic      en_q, en_d;
  logic      dir_q, dir_d;
  logic      dir_ld;

  always_comb begin
    state_d  = state_q;
    en_d     = 1'b0;
    dir_d    = dir_q;
    dir_ld   = 1'b0;
    accept_o = 1'b0;
    unique case (state_q)
      PS_IDLE: begin
        if (!at_tgt_i) begin
          state_d = PS_WAIT;
          en_d    = 1'b1;
          dir_d   = go_inc_i;
          dir_ld  = 1'b1;
        end
      end
      PS_WAIT: begin
        if (done_i) begin
          state_d  = PS_IDLE;
          accept_o = 1'b1;
        end
      end
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      en_q    <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      en_q    <= en_d;
      if (dir_ld) dir_q <= dir_d;
    end
  end

  assign en_o     = en_q;
  assign incdec_o = dir_q;
  assign wait_o   = (state_q == PS_WAIT);

endmodule

// File: rtl/ps_fine_ctrl.sv
module ps_fine_ctrl #(
  parameter  int STEPS = 56,
  localparam int PW    = $clog2(STEPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic signed [PW:0]   req_phase,
  output logic                 ready,
  output logic                 busy,
  output logic [PW-1:0]        cur_phase,
  output logic                 ps_en,
  output logic                 ps_incdec,
  input  logic                 ps_done
);

  localparam logic [PW:0] STEPS_W = (PW+1)'(STEPS);

  logic          rst_i_n;
  logic [PW:0]   req_u;
  logic [PW:0]   tgt_q, tgt_d;
  logic          at_tgt, go_inc, accept, waiting;
  logic [PW-1:0] cur;

  ps_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // Negative targets fold into the upper part of the index range.
  assign req_u = $unsigned(req_phase);

  always_comb begin
    tgt_d = req_phase[PW] ? (req_u + STEPS_W) : req_u;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)       tgt_q <= '0;
    else if (req_valid) tgt_q <= tgt_d;
  end

  ps_dir_pick #(.STEPS(STEPS), .PW(PW)) u_dir (
    .cur_i    (cur),
    .tgt_i    (tgt_q),
    .at_tgt_o (at_tgt),
    .go_inc_o (go_inc)
  );

  ps_step_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .at_tgt_i (at_tgt),
    .go_inc_i (go_inc),
    .done_i   (ps_done),
    .en_o     (ps_en),
    .incdec_o (ps_incdec),
    .accept_o (accept),
    .wait_o   (waiting)
  );

  ps_phase_acc #(.STEPS(STEPS), .PW(PW)) u_acc (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .step_i (accept),
    .inc_i  (ps_incdec),
    .cur_o  (cur)
  );

  assign cur_phase = cur;
  assign busy      = waiting | ~at_tgt;
  assign ready     = ~busy;

endmodule

// File: rtl/ps_fine_ctrl_chk.sv
module ps_fine_ctrl_chk #(
  parameter  int STEPS = 56,
  localparam int PW    = $clog2(STEPS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic [PW-1:0] cur_phase,
  input logic          ps_en,
  input logic          ps_incdec,
  input logic          ps_done
);

  logic out_q;   // step outstanding, as seen from the port pins

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_q <= 1'b0;
    else if (ps_en)   out_q <= 1'b1;
    else if (ps_done) out_q <= 1'b0;
  end

  function automatic logic [PW-1:0] up1(input logic [PW-1:0] v);
    return (v == PW'(STEPS - 1)) ? '0 : v + 1'b1;
  endfunction

  function automatic logic [PW-1:0] dn1(input logic [PW-1:0] v);
    return (v == '0) ? PW'(STEPS - 1) : v - 1'b1;
  endfunction

  p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ps_en |-> !out_q);

  p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ps_en |=> !ps_en);

  p_wrap_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q && ps_done) |=>
      (cur_phase == ($past(ps_incdec) ? up1($past(cur_phase)) : dn1($past(cur_phase)))));

  p_ready_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!ps_en && !out_q));

  p_stray_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_q |=> $stable(cur_phase));

  p_index_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cur_phase < PW'(STEPS));

endmodule

bind ps_fine_ctrl ps_fine_ctrl_chk #(.STEPS(STEPS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ready     (ready),
  .cur_phase (cur_phase),
  .ps_en     (ps_en),
  .ps_incdec (ps_incdec),
  .ps_done   (ps_done)
);

// File: tb/ps_fine_ctrl_bench.sv
module ps_fine_ctrl_bench;

  localparam int STEPS = 56;
  localparam int PW    = $clog2(STEPS);

  logic                clk = 1'b0;
  logic                rst_n;
  logic                req_valid;
  logic signed [PW:0]  req_phase;
  logic                ready, busy, ps_en, ps_incdec;
  logic [PW-1:0]       cur_phase;
  logic                resp_done, stray_done;
  logic                ps_done;

  assign ps_done = resp_done | stray_done;

  always #2 clk = ~clk;   // 250 MHz

  ps_fine_ctrl #(.STEPS(STEPS)) u_ps_fine_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_phase (req_phase),
    .ready     (ready),
    .busy      (busy),
    .cur_phase (cur_phase),
    .ps_en     (ps_en),
    .ps_incdec (ps_incdec),
    .ps_done   (ps_done)
  );

  int checks = 0;
  int fails  = 0;
  int m_cur, m_tgt, pulses, en_twice, en_stacked;
  bit m_out, m_dir, last_en;

  function automatic int norm(input int t);
    return (t < 0) ? t + STEPS : t;
  endfunction

  function automatic int fwd_of(input int c, input int t);
    return (t - c + STEPS) % STEPS;
  endfunction

  function automatic int min_steps(input int c, input int t);
    int f = fwd_of(c, t);
    return (f <= STEPS - f) ? f : STEPS - f;
  endfunction

  function automatic bit want_inc(input int c, input int t);
    int f = fwd_of(c, t);
    return (f <= STEPS - f);
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Pin-level model: tracks index, target and outstanding step.
  initial begin
    m_cur = 0; m_tgt = 0; m_out = 0; m_dir = 0; last_en = 0;
    pulses = 0; en_twice = 0; en_stacked = 0;
    forever begin
      @(posedge clk);
      #1;
      if (!rst_n) begin
        m_cur = 0; m_tgt = 0; m_out = 0; last_en = 0;
      end else begin
        if (ps_done && m_out) begin
          m_cur = m_dir ? (m_cur + 1) % STEPS : (m_cur + STEPS - 1) % STEPS;
          m_out = 0;
        end
        if (ps_en) begin
          if (last_en) en_twice++;
          if (m_out)   en_stacked++;
          pulses++;
          // R6: shorter direction, tie goes up
          chk(ps_incdec == want_inc(m_cur, m_tgt), "R6 direction", ps_incdec,
              want_inc(m_cur, m_tgt));
          m_dir = ps_incdec;
          m_out = 1;
        end
        last_en = ps_en;
        if (req_valid) m_tgt = norm(int'(req_phase));
      end
    end
  end

  // Behavioural responder: done after 3..12 port clocks.
  initial begin
    resp_done = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && ps_en) begin
        int w = 3 + int'($urandom % 10);
        repeat (w - 1) @(posedge clk);
        @(negedge clk);
        resp_done = 1'b1;
        @(negedge clk);
        resp_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic send(input int t);
    @(negedge clk);
    req_valid = 1'b1;
    req_phase = (PW+1)'(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    while (!ready) @(negedge clk);
  endtask

  task automatic move(input int t, input string rq);
    int start = int'(cur_phase);
    int p0    = pulses;
    send(t);
    settle();
    chk(int'(cur_phase) == norm(t), {rq, " final index"}, int'(cur_phase), norm(t));
    chk(pulses - p0 == min_steps(start, norm(t)), "R7 step count", pulses - p0,
        min_steps(start, norm(t)));
  endtask

  initial begin
    int p0, hold;
    void'($urandom(32'd4711));
    rst_n = 1'b0; req_valid = 1'b0; req_phase = '0; stray_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(cur_phase == '0, "R1 index", int'(cur_phase), 0);
    chk(ready == 1'b1, "R1 ready", ready, 1);
    chk(ps_en == 1'b0, "R1 ps_en", ps_en, 0);

    move(10, "R5 up");
    // R2: -1 names 55; shorter path crosses 0 downward (R5 wrap)
    move(-1, "R2 negative");
    // R6 tie: 55 -> 27 is 28 either way, must go up through 0
    move(27, "R6 tie");

    // R9: same target, no step, ready stays
    p0 = pulses;
    send(27);
    chk(ready == 1'b1, "R9 ready held", ready, 1);
    repeat (3) @(negedge clk);
    chk(pulses == p0, "R9 no pulse", pulses - p0, 0);
    chk(busy == 1'b0, "R9 busy", busy, 0);

    // R10: unsolicited done while idle
    hold = int'(cur_phase);
    @(negedge clk); stray_done = 1'b1;
    @(negedge clk); stray_done = 1'b0;
    repeat (2) @(negedge clk);
    chk(int'(cur_phase) == hold, "R10 stray done", int'(cur_phase), hold);

    // R8: retarget while the first step is outstanding
    p0 = pulses;
    send(40);
    while (pulses == p0) @(negedge clk);
    send(20);
    settle();
    chk(int'(cur_phase) == 20, "R8 newest target", int'(cur_phase), 20);
    chk(pulses - p0 == 9, "R8 step count", pulses - p0, 9);

    // random targets across the full signed range
    for (int i = 0; i < 20; i++) begin
      int t = int'($urandom_range(110, 0)) - 55;
      move(t, "R2 random");
      chk(int'(cur_phase) < STEPS, "R11 range", int'(cur_phase), STEPS - 1);
    end

    // directed: wrap up from 55 by one step, then down from 0
    move(55, "R5 set 55");
    move(0, "R5 up wrap");
    move(-1, "R5 down wrap");

    repeat (4) @(negedge clk);
    chk(en_stacked == 0, "R3 overlap", en_stacked, 0);
    chk(en_twice == 0, "R4 pulse width", en_twice, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule